// File: doc/BRIEF.md
# Interval Slowdown Estimator

This block runs beside one core and estimates, once per fixed window of clock cycles, how much slower that core runs because it shares the last-level cache and main memory with other cores. It observes per-cycle strobes: a shared-cache access by the core, a flag saying the core currently holds top priority at the memory controller, a flag saying the core has a memory request waiting, the identity of the core whose request the controller scheduled last, a miss completion with its latency, and a strobe for each miss that an auxiliary tag store classifies as a contention miss.

The shared access rate is the total number of accesses in the window divided by the window length. The alone access rate is estimated from the top-priority periods only. It is the number of accesses made while the core held top priority, divided by the top-priority cycle count less the cycles lost to cache contention and less the cycles spent queued behind another core's request. Cache contention cycles are the contention-miss count multiplied by the mean miss latency, and that mean is taken over misses that completed while the core held top priority. The slowdown is the alone rate divided by the shared rate. It is produced as an unsigned fixed-point number with eight fraction bits, computed by a shared multi-cycle restoring divider, and marked with a one-cycle done pulse.

Top module: `slowdown_estimator`

## Requirements
- R1: While reset is asserted and until the first result, `slow_o` reads 0x0100 (1.0), `flag_o` reads 0 and `done_o` reads 0.
- R2: For each window of `INTERVAL` cycles counted from the first clock edge after reset release, exactly one single-cycle `done_o` pulse is produced, before the following window ends, and results come out in window order.
- R3: With A = accesses in the window, H = top-priority cycles, HA = accesses during top-priority cycles, Q = queueing cycles and C = contention cycles, `slow_o` = floor(HA x INTERVAL x 256 / ((H - C - Q) x A)) and `flag_o` = 0 when H - C - Q > 0 and A > 0.
- R4: Mean miss latency is floor(sum of `miss_lat_i` / count) over cycles where `miss_done_i` and `hp_i` are both 1; it is 0 when no such completion occurs. Completions while `hp_i` is 0 have no effect on the result.
- R5: A cycle is a queueing cycle when `hp_i`, `pend_i` are 1 and `owner_i` differs from `CORE_ID`. With `owner_i` equal to `CORE_ID` no queueing is counted.
- R6: Contention cycles C = (count of cycles with `cont_miss_i` and `hp_i` both 1) x mean miss latency. When H - C - Q <= 0, the result is 0x0100 with `flag_o` = 1.
- R7: When the window holds no cache access (A = 0), the result is 0x0100 with `flag_o` = 1.
- R8: A quotient that does not fit in `OUT_W` bits is reported as all ones (0xFFFF by default).
- R9: Every count starts from zero in each window; events in the last cycle of a window belong to that window.
- R10: `slow_o` and `flag_o` change only in the cycle where `done_o` is 1 and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 1 | Core made a shared-cache access this cycle |
| hp_i | input | 1 | Core holds top memory priority this cycle |
| pend_i | input | 1 | Core has a memory request outstanding |
| owner_i | input | OWN_W | Core whose request was scheduled last |
| miss_done_i | input | 1 | A miss of this core completed this cycle |
| miss_lat_i | input | LAT_W | Latency in cycles of the completing miss |
| cont_miss_i | input | 1 | A contention miss was detected this cycle |
| slow_o | output | OUT_W | Slowdown estimate, FRAC_W fraction bits |
| flag_o | output | 1 | Result is the fallback value 1.0 |
| done_o | output | 1 | One-cycle pulse: new result on slow_o and flag_o |

## Verification
The window boundary and the event counting fall in the same cycle: on the last cycle of a window every counter must both take that cycle's strobe into the closing snapshot and restart at zero for the next window. The bench drives random strobes on every cycle, including each window's final one, with windows back to back, and computes each window's expected result from its own record of what it drove in cycles 0 to INTERVAL-1 of that window. A strobe that leaks into the wrong window or is dropped shows up as a result mismatch. A second overlap, the done pulse of one window arriving while the next window is being counted, is judged by checking that every result is taken in order and that `slow_o` has not moved between pulses.

// File: rtl/sd_pkg.sv
package sd_pkg;
   // event counter indices inside the snapshot vector
   localparam int EV_ACC   = 0;
   localparam int EV_HP    = 1;
   localparam int EV_HPACC = 2;
   localparam int EV_Q     = 3;
   localparam int EV_MISS  = 4;
   localparam int EV_CONT  = 5;
   localparam int NEV      = 6;

   typedef enum logic [1:0] {
      S_IDLE,
      S_AVG,
      S_MUL,
      S_SLOW
   } sd_state_t;
endpackage

// File: rtl/sd_counters.sv
module sd_counters #(
   parameter int INTERVAL = 1024,
   parameter int LAT_W    = 8,
   parameter int OWN_W    = 2,
   parameter int CORE_ID  = 0,
   parameter int IW       = 11,
   parameter int SW       = 19
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            acc_i,
   input  logic                            hp_i,
   input  logic                            pend_i,
   input  logic [OWN_W-1:0]                owner_i,
   input  logic                            miss_done_i,
   input  logic [LAT_W-1:0]                miss_lat_i,
   input  logic                            cont_miss_i,
   output logic [sd_pkg::NEV-1:0][IW-1:0]  snap_o,
   output logic [SW-1:0]                   lat_snap_o,
   output logic                            snap_v_o
);
   import sd_pkg::*;

   logic [IW-1:0]  cyc;
   logic           last;
   logic [NEV-1:0] ev;
   logic [SW-1:0]  lat_cnt;
   logic [SW-1:0]  lat_inc;

   assign last = (cyc == IW'(INTERVAL - 1));

   // per-cycle event decode
   always_comb begin
      ev           = '0;
      ev[EV_ACC]   = acc_i;
      ev[EV_HP]    = hp_i;
      ev[EV_HPACC] = hp_i & acc_i;
      ev[EV_Q]     = hp_i & pend_i & (owner_i != OWN_W'(CORE_ID));
      ev[EV_MISS]  = hp_i & miss_done_i;
      ev[EV_CONT]  = hp_i & cont_miss_i;
   end

   assign lat_inc = ev[EV_MISS] ? SW'(miss_lat_i) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc      <= '0;
         snap_v_o <= 1'b0;
      end else begin
         cyc      <= last ? '0 : cyc + 1'b1;
         snap_v_o <= last;
      end
   end

   genvar g;
   for (g = 0; g < NEV; g++) begin : g_ev
      logic [IW-1:0] cnt;
      logic [IW-1:0] snap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt  <= '0;
            snap <= '0;
         end else if (last) begin
            snap <= cnt + IW'(ev[g]);
            cnt  <= '0;
         end else begin
            cnt  <= cnt + IW'(ev[g]);
         end
      end
      assign snap_o[g] = snap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt    <= '0;
         lat_snap_o <= '0;
      end else if (last) begin
         lat_snap_o <= lat_cnt + lat_inc;
         lat_cnt    <= '0;
      end else begin
         lat_cnt    <= lat_cnt + lat_inc;
      end
   end
endmodule

// File: rtl/sd_div.sv
module sd_div #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] num_i,
   input  logic [DW-1:0] den_i,
   output logic [DW-1:0] quot_o,
   output logic          done_o
);
   localparam int CW = $clog2(DW + 1);

   logic [DW:0]   rem;
   logic [DW-1:0] quo;
   logic [CW-1:0] cnt;
   logic          busy;
   logic [DW:0]   trial;
   logic          ge;

   assign trial  = {rem[DW-1:0], quo[DW-1]};
   assign ge     = (trial >= {1'b0, den_i});
   assign quot_o = quo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem    <= '0;
         quo    <= '0;
         cnt    <= '0;
         busy   <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            rem  <= '0;
            quo  <= num_i;
            cnt  <= CW'(DW);
            busy <= 1'b1;
         end else if (busy) begin
            rem <= ge ? (trial - {1'b0, den_i}) : trial;
            quo <= {quo[DW-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy   <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/slowdown_estimator.sv
module slowdown_estimator #(
   parameter int INTERVAL = 1024,
   parameter int LAT_W    = 8,
   parameter int OWN_W    = 2,
   parameter int CORE_ID  = 0,
   parameter int FRAC_W   = 8,
   parameter int OUT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_i,
   input  logic             hp_i,
   input  logic             pend_i,
   input  logic [OWN_W-1:0] owner_i,
   input  logic             miss_done_i,
   input  logic [LAT_W-1:0] miss_lat_i,
   input  logic             cont_miss_i,
   output logic [OUT_W-1:0] slow_o,
   output logic             flag_o,
   output logic             done_o
);
   import sd_pkg::*;

   localparam int IW  = $clog2(INTERVAL + 1);
   localparam int SW  = IW + LAT_W;
   localparam int RW  = 2 * IW + FRAC_W;
   localparam int DW  = (RW > SW) ? RW : SW;
   localparam logic [OUT_W-1:0] ONE = OUT_W'(1) << FRAC_W;

   if (INTERVAL < 2 * DW + 16) begin : g_bad_interval
      $error("INTERVAL too short for the divider latency");
   end
   if (OUT_W <= FRAC_W) begin : g_bad_out
      $error("OUT_W must exceed FRAC_W");
   end
   if (CORE_ID >= (1 << OWN_W)) begin : g_bad_id
      $error("CORE_ID does not fit in OWN_W bits");
   end

   logic [NEV-1:0][IW-1:0] snap;
   logic [SW-1:0]          lat_snap;
   logic                   snap_v;

   sd_counters #(
      .INTERVAL(INTERVAL), .LAT_W(LAT_W), .OWN_W(OWN_W),
      .CORE_ID(CORE_ID), .IW(IW), .SW(SW)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .hp_i(hp_i),
      .pend_i(pend_i), .owner_i(owner_i), .miss_done_i(miss_done_i),
      .miss_lat_i(miss_lat_i), .cont_miss_i(cont_miss_i),
      .snap_o(snap), .lat_snap_o(lat_snap), .snap_v_o(snap_v)
   );

   sd_state_t      st;
   logic           busy;
   logic           div_start;
   logic [DW-1:0]  div_num;
   logic [DW-1:0]  div_den;
   logic [DW-1:0]  quot;
   logic           div_done;
   logic [LAT_W-1:0] avg_q;

   sd_div #(.DW(DW)) u_div (
      .clk(clk), .rst_n(rst_n), .start_i(div_start),
      .num_i(div_num), .den_i(div_den), .quot_o(quot), .done_o(div_done)
   );

   assign busy = (st != S_IDLE);

   // corrected top-priority cycle count and ratio operands
   logic [SW-1:0]        cont_w;
   logic signed [SW+1:0] den_s;
   logic [DW-1:0]        num_w;
   logic [DW-1:0]        prod_w;
   logic                 fallback;
   logic [OUT_W-1:0]     sat_q;

   assign cont_w   = SW'(snap[EV_CONT]) * SW'(avg_q);
   assign den_s    = $signed({2'b00, SW'(snap[EV_HP])})
                   - $signed({2'b00, cont_w})
                   - $signed({2'b00, SW'(snap[EV_Q])});
   assign num_w    = (DW'(snap[EV_HPACC]) * DW'(INTERVAL)) << FRAC_W;
   assign prod_w   = DW'(den_s[IW-1:0]) * DW'(snap[EV_ACC]);
   assign fallback = (den_s <= 0) || (snap[EV_ACC] == '0);

   if (DW > OUT_W) begin : g_sat
      assign sat_q = (|quot[DW-1:OUT_W]) ? '1 : quot[OUT_W-1:0];
   end else begin : g_nosat
      assign sat_q = OUT_W'(quot);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         div_start <= 1'b0;
         div_num   <= '0;
         div_den   <= '0;
         avg_q     <= '0;
         slow_o    <= ONE;
         flag_o    <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         div_start <= 1'b0;
         done_o    <= 1'b0;
         case (st)
            S_IDLE: if (snap_v) begin
               div_num   <= DW'(lat_snap);
               div_den   <= DW'(snap[EV_MISS]);
               div_start <= 1'b1;
               st        <= S_AVG;
            end
            S_AVG: if (div_done) begin
               avg_q <= (snap[EV_MISS] == '0) ? '0 : quot[LAT_W-1:0];
               st    <= S_MUL;
            end
            S_MUL: begin
               if (fallback) begin
                  slow_o <= ONE;
                  flag_o <= 1'b1;
                  done_o <= 1'b1;
                  st     <= S_IDLE;
               end else begin
                  div_num   <= num_w;
                  div_den   <= prod_w;
                  div_start <= 1'b1;
                  st        <= S_SLOW;
               end
            end
            S_SLOW: if (div_done) begin
               slow_o <= sat_q;
               flag_o <= 1'b0;
               done_o <= 1'b1;
               st     <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
   parameter int OUT_W  = 16,
   parameter int FRAC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done_o,
   input logic             flag_o,
   input logic [OUT_W-1:0] slow_o,
   input logic             snap_v,
   input logic             busy
);
   localparam logic [OUT_W-1:0] ONE = OUT_W'(1) << FRAC_W;

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // a new window snapshot never arrives while the previous one is in flight
   p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      snap_v |-> !busy);

   p_flag_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && flag_o) |-> (slow_o == ONE));

   p_hold_val_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(slow_o));

   p_hold_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(flag_o));
endmodule

bind slowdown_estimator sd_checker #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done_o(done_o), .flag_o(flag_o),
   .slow_o(slow_o), .snap_v(snap_v), .busy(busy)
);

// File: tb/tb_slowdown_estimator.sv
module tb_slowdown_estimator;
   localparam int CLK_P = 10;
   localparam int IV    = 256;
   localparam int CID   = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_i = 0, hp_i = 0, pend_i = 0, miss_done_i = 0, cont_miss_i = 0;
   logic [1:0] owner_i = 2'd0;
   logic [7:0] miss_lat_i = 8'd0;
   logic [15:0] slow_o;
   logic       flag_o, done_o;

   always #(CLK_P / 2) clk = ~clk;

   slowdown_estimator #(.INTERVAL(IV), .LAT_W(8), .OWN_W(2), .CORE_ID(CID),
                        .FRAC_W(8), .OUT_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .hp_i(hp_i), .pend_i(pend_i),
      .owner_i(owner_i), .miss_done_i(miss_done_i), .miss_lat_i(miss_lat_i),
      .cont_miss_i(cont_miss_i), .slow_o(slow_o), .flag_o(flag_o), .done_o(done_o)
   );

   int checks = 0, fails = 0;
   int exp_v[64];
   bit exp_f[64];
   string exp_t[64];
   int wr = 0, rd = 0;
   bit finished = 0;
   bit hold_ok = 1;
   logic [15:0] last_v = 16'h0100;
   logic        last_f = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic void model(input longint a, h, ha, q, m, ls, c,
                                 output int v, output bit f);
      longint avg, den, r;
      avg = (m != 0) ? ls / m : 0;
      den = h - c * avg - q;
      if (den <= 0 || a == 0) begin
         v = 256; f = 1;
      end else begin
         r = (ha * IV * 256) / (den * a);
         v = (r > 65535) ? 65535 : int'(r);
         f = 0;
      end
   endfunction

   // one window of stimulus; percentages per strobe, latency 1..lmax in top priority, 255 otherwise
   task automatic run_iv(input int ph, pa, pp, po, pm, pc, lmax, bit sat, string tag);
      longint a = 0, h = 0, ha = 0, q = 0, m = 0, ls = 0, c = 0;
      int v; bit f;
      for (int cy = 0; cy < IV; cy++) begin
         if (sat) begin
            hp_i = (cy == 0); acc_i = (cy == 0);
            pend_i = 0; miss_done_i = 0; cont_miss_i = 0;
         end else begin
            hp_i        = (($urandom % 100) < ph);
            acc_i       = (($urandom % 100) < pa);
            pend_i      = (($urandom % 100) < pp);
            miss_done_i = (($urandom % 100) < pm);
            cont_miss_i = (($urandom % 100) < pc);
         end
         owner_i    = (($urandom % 100) < po) ? 2'd2 : 2'(CID);
         miss_lat_i = hp_i ? 8'(1 + ($urandom % lmax)) : 8'd255;
         a  += acc_i;
         h  += hp_i;
         ha += (hp_i & acc_i);
         q  += (hp_i & pend_i & (owner_i != 2'(CID)));
         if (hp_i && miss_done_i) begin m++; ls += miss_lat_i; end
         c  += (hp_i & cont_miss_i);
         @(negedge clk);
      end
      model(a, h, ha, q, m, ls, c, v, f);
      exp_v[wr] = v; exp_f[wr] = f; exp_t[wr] = tag;
      wr++;
   endtask

   // result monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_o) begin
            chk(hold_ok, "R10 hold", slow_o, last_v);
            if (rd < wr) begin
               chk(slow_o == 16'(exp_v[rd]), {exp_t[rd], " value"}, slow_o, exp_v[rd]);
               chk(flag_o == exp_f[rd], {exp_t[rd], " flag"}, flag_o, exp_f[rd]);
               rd++;
            end else begin
               chk(0, "R2 unexpected done", rd, wr);
            end
            last_v = slow_o; last_f = flag_o; hold_ok = 1;
         end else if (slow_o != last_v || flag_o != last_f) begin
            hold_ok = 0;
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(slow_o == 16'h0100, "R1 reset value", slow_o, 256);
      chk(flag_o == 1'b0, "R1 reset flag", flag_o, 0);
      chk(done_o == 1'b0, "R1 reset done", done_o, 0);
      rst_n = 1'b1;
      // directed corners
      run_iv(100, 60, 0, 0, 0, 0, 4, 0, "R3 unity");
      run_iv(100, 50, 0, 0, 0, 0, 4, 0, "R3 unity2");
      run_iv(50, 0, 30, 50, 10, 5, 8, 0, "R7 no access");
      run_iv(100, 50, 0, 0, 40, 100, 20, 0, "R6 contention");
      run_iv(0, 0, 0, 0, 0, 0, 1, 1, "R8 saturate");
      run_iv(100, 70, 100, 0, 0, 0, 4, 0, "R5 own core");
      run_iv(100, 70, 100, 100, 0, 0, 4, 0, "R5 other core");
      run_iv(100, 70, 100, 40, 0, 0, 4, 0, "R5 mixed");
      run_iv(40, 60, 20, 50, 30, 2, 6, 0, "R4 latency");
      // random windows back to back
      for (int k = 0; k < 16; k++) begin
         run_iv($urandom % 101, 1 + $urandom % 100, $urandom % 101, $urandom % 101,
                $urandom % 40, $urandom % 8, 1 + $urandom % 30, 0, "R9 R3 random");
      end
      acc_i = 0; hp_i = 0; pend_i = 0; miss_done_i = 0; cont_miss_i = 0;
      repeat (IV / 2) @(negedge clk);
      chk(rd == wr, "R2 done count", rd, wr);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule